// File: doc/BRIEF.md
# Quad-Line Serial Flash Command Decoder

This block sits at the front of a serial flash slave that moves four bits per serial clock on a quad data bus. A frame opens when chip select falls. The first two nibbles form the opcode, with the high nibble first. The block looks the opcode up to learn its shape: whether three address bytes follow, whether ten dummy clocks follow, and how many data bytes may be moved in which direction. It then walks the address, dummy and data phases. For reads it issues one request per byte slot to the back end that supplies the data. For writes it forwards each received data byte. When chip select rises it emits a single commit pulse carrying the opcode, address and accepted byte count, provided every required phase of the frame has completed.

The back end reports an internal modify cycle through a busy level. While that level is high, the decoder accepts only the status poll, the flag poll and the suspend command. Any other command is dropped silently for the rest of the frame. Serial clocks arrive as a one-cycle strobe in the system clock domain. Neither output stream can stall, because the serial link cannot wait: the consumer must take each `rd_req` and `wr_valid` pulse in the cycle it appears.

Top module: `qfd_top`

## Requirements
- R1: A byte is two strobed nibbles, high nibble first. The opcode is the first byte of a frame. An opcode outside the recognised set (AFh, 0Bh, 6Bh, EBh, 4Bh, 06h, 04h, 02h, 32h, 12h, 42h, 20h, D8h, C7h, 7Ah, 75h, 05h, 01h, E8h, E5h, 70h, 50h, B5h) produces no request, no write byte and no commit until the next frame.
- R2: Opcodes 0Bh, 6Bh, EBh, 4Bh, 02h, 32h, 12h, 42h, 20h, D8h, E8h and E5h take three address bytes, most significant byte first. The address is reported on `cmd_addr`.
- R3: For 0Bh, 6Bh, EBh and 4Bh, exactly ten serial strobes pass between the last address byte and the first read request. A frame that ends inside those strobes issues nothing.
- R4: A read issues one `rd_req` on entering its data phase and one after each completed data byte, up to a cap. The cap is 3 for AFh, 65 for 4Bh and 2 for B5h. There is no cap for 0Bh, 6Bh, EBh, 05h, E8h and 70h. `rd_req` and `wr_valid` never assert together.
- R5: Write data bytes are forwarded on `wr_valid`/`wr_data` up to a limit. The limit is 256 for 02h, 32h and 12h, 65 for 42h, and 1 for 01h and E5h. Further bytes are dropped.
- R6: `cmd_commit` pulses for one cycle after chip select rises. It pulses only when the frame reached its data phase and, for a write command, at least one byte was forwarded. A truncated frame does not commit.
- R7: The `busy` level is sampled when the opcode completes. If it is high, only 05h, 70h and 75h are accepted. Every other opcode behaves as in R1.
- R8: During a commit, `cmd_op` holds the opcode, `cmd_addr` holds the address, and `cmd_nbytes` holds the forwarded write byte count (0 for non-write commands).
- R9: After reset, `rd_req`, `wr_valid` and `cmd_commit` are low.
- R10: Commands without address or data (06h, 04h, C7h, 7Ah, 75h, 50h) ignore any extra nibbles and still commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low; high ends the frame |
| sck_en | input | 1 | One-cycle strobe per serial clock |
| io_in | input | 4 | Quad data nibble, sampled with `sck_en` |
| busy | input | 1 | Internal modify cycle in progress |
| rd_req | output | 1 | Request for the next read data byte |
| wr_valid | output | 1 | Write data byte valid (no back-pressure) |
| wr_data | output | 8 | Write data byte |
| cmd_commit | output | 1 | Frame completed, command may take effect |
| cmd_op | output | 8 | Opcode of the current or last frame |
| cmd_addr | output | 24 | Address of the current or last frame |
| cmd_nbytes | output | 9 | Forwarded write byte count |

## Verification
The stimulus covers each shape of command: no-address commands padded with surplus nibbles, capped and uncapped reads, reads with and without dummy clocks, writes below and above their limits, and writes with no data. Together these separate the per-opcode table entries from one another. Frames are cut short inside the address and dummy phases to show that the commit depends on phase completion and not merely on chip select rising. Unknown opcodes, and the same opcodes sent with busy raised, tell the recognition filter apart from the busy gating. A behavioural model predicts every pulse cycle by cycle, so an off-by-one in the dummy count or a cap shows up directly.

// File: rtl/qfd_pkg.sv
package qfd_pkg;
  localparam int ADR_BYTES = 3;
  localparam int ADDR_W    = 8 * ADR_BYTES;
  localparam int DMY_CLKS  = 10;
  localparam int DMY_W     = $clog2(DMY_CLKS + 1);
  localparam int PROG_MAX  = 256;
  localparam int OTP_MAX   = 65;
  localparam int CNT_W     = $clog2(PROG_MAX + 1);

  typedef struct packed {
    logic             known;
    logic             has_addr;
    logic [DMY_W-1:0] ndummy;
    logic             rd;
    logic             wr;
    logic [CNT_W-1:0] dmax;    // 0 = uncapped read
    logic             busy_ok;
  } op_shape_t;

  function automatic op_shape_t shape_of(input logic [7:0] op);
    op_shape_t s;
    s = '0;
    s.known = 1'b1;
    case (op)
      8'hAF: begin s.rd = 1'b1; s.dmax = CNT_W'(3); end
      8'h0B, 8'h6B, 8'hEB: begin
        s.has_addr = 1'b1; s.ndummy = DMY_W'(DMY_CLKS); s.rd = 1'b1;
      end
      8'h4B: begin
        s.has_addr = 1'b1; s.ndummy = DMY_W'(DMY_CLKS); s.rd = 1'b1;
        s.dmax = CNT_W'(OTP_MAX);
      end
      8'h02, 8'h32, 8'h12: begin
        s.has_addr = 1'b1; s.wr = 1'b1; s.dmax = CNT_W'(PROG_MAX);
      end
      8'h42: begin s.has_addr = 1'b1; s.wr = 1'b1; s.dmax = CNT_W'(OTP_MAX); end
      8'h20, 8'hD8: s.has_addr = 1'b1;
      8'h06, 8'h04, 8'hC7, 8'h7A, 8'h50: ;
      8'h75: s.busy_ok = 1'b1;
      8'h05, 8'h70: begin s.rd = 1'b1; s.busy_ok = 1'b1; end
      8'h01: begin s.wr = 1'b1; s.dmax = CNT_W'(1); end
      8'hE8: begin s.has_addr = 1'b1; s.rd = 1'b1; end
      8'hE5: begin s.has_addr = 1'b1; s.wr = 1'b1; s.dmax = CNT_W'(1); end
      8'hB5: begin s.rd = 1'b1; s.dmax = CNT_W'(2); end
      default: s.known = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/qfd_nib_pack.sv
module qfd_nib_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck_en,
  input  logic [3:0] io_in,
  output logic       nib_stb,
  output logic       byte_stb,
  output logic [7:0] byte_val
);
  logic       half_q;
  logic [3:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      hi_q   <= '0;
    end else if (cs_n) begin
      half_q <= 1'b0;
    end else if (sck_en) begin
      half_q <= ~half_q;
      if (!half_q) hi_q <= io_in;
    end
  end

  assign nib_stb  = !cs_n && sck_en;
  assign byte_stb = nib_stb && half_q;
  assign byte_val = {hi_q, io_in};
endmodule

// File: rtl/qfd_shape_lut.sv
module qfd_shape_lut
  import qfd_pkg::*;
(
  input  logic [7:0] op,
  output op_shape_t  shape
);
  always_comb shape = shape_of(op);
endmodule

// File: rtl/qfd_seq.sv
module qfd_seq
  import qfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              busy,
  input  logic              nib_stb,
  input  logic              byte_stb,
  input  logic [7:0]        byte_val,
  input  op_shape_t         shape,
  output logic              rd_req,
  output logic              wr_valid,
  output logic [7:0]        wr_data,
  output logic              cmd_commit,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CNT_W-1:0]  cmd_nbytes
);
  typedef enum logic [2:0] {S_OPC, S_ADDR, S_DUMMY, S_DATA, S_SKIP} st_t;
  localparam int ACNT_W = $clog2(ADR_BYTES + 1);

  st_t              st;
  op_shape_t        shp;
  op_shape_t        nshp;
  logic [ACNT_W-1:0] acnt;
  logic [DMY_W-1:0] dmy;
  logic [CNT_W-1:0] dcnt;
  logic             cs_q;
  logic             accept;
  logic             enter_data;

  always_comb begin
    nshp   = (st == S_OPC) ? shape : shp;
    accept = shape.known && (!busy || shape.busy_ok);
    enter_data = 1'b0;
    if (!cs_n) begin
      case (st)
        S_OPC:   enter_data = byte_stb && accept && !shape.has_addr;
        S_ADDR:  enter_data = byte_stb && (acnt == ACNT_W'(ADR_BYTES - 1)) &&
                              (shp.ndummy == '0);
        S_DUMMY: enter_data = nib_stb && (dmy == shp.ndummy - DMY_W'(1));
        default: enter_data = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_OPC;
      shp        <= '0;
      acnt       <= '0;
      dmy        <= '0;
      dcnt       <= '0;
      cs_q       <= 1'b1;
      rd_req     <= 1'b0;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
      cmd_commit <= 1'b0;
      cmd_op     <= '0;
      cmd_addr   <= '0;
      cmd_nbytes <= '0;
    end else begin
      rd_req     <= 1'b0;
      wr_valid   <= 1'b0;
      cmd_commit <= 1'b0;
      cs_q       <= cs_n;
      if (cs_n) begin
        if (!cs_q) begin
          cmd_commit <= (st == S_DATA) && (!shp.wr || dcnt != '0);
          cmd_nbytes <= shp.wr ? dcnt : '0;
        end
        st   <= S_OPC;
        acnt <= '0;
        dmy  <= '0;
        dcnt <= '0;
      end else begin
        if (enter_data) begin
          st     <= S_DATA;
          rd_req <= nshp.rd;
          dcnt   <= nshp.rd ? CNT_W'(1) : '0;
        end
        case (st)
          S_OPC: if (byte_stb) begin
            cmd_op   <= byte_val;
            cmd_addr <= '0;
            shp      <= shape;
            if (!accept)             st <= S_SKIP;
            else if (shape.has_addr) st <= S_ADDR;
          end
          S_ADDR: if (byte_stb) begin
            cmd_addr <= {cmd_addr[ADDR_W-9:0], byte_val};
            acnt     <= acnt + ACNT_W'(1);
            if (acnt == ACNT_W'(ADR_BYTES - 1) && shp.ndummy != '0)
              st <= S_DUMMY;
          end
          S_DUMMY: if (nib_stb) dmy <= dmy + DMY_W'(1);
          S_DATA: if (byte_stb) begin
            if (shp.wr && dcnt < shp.dmax) begin
              wr_valid <= 1'b1;
              wr_data  <= byte_val;
              dcnt     <= dcnt + CNT_W'(1);
            end
            if (shp.rd && (shp.dmax == '0 || dcnt < shp.dmax)) begin
              rd_req <= 1'b1;
              if (shp.dmax != '0) dcnt <= dcnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qfd_top.sv
module qfd_top
  import qfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_en,
  input  logic [3:0]        io_in,
  input  logic              busy,
  output logic              rd_req,
  output logic              wr_valid,
  output logic [7:0]        wr_data,
  output logic              cmd_commit,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CNT_W-1:0]  cmd_nbytes
);
  logic      nib_stb;
  logic      byte_stb;
  logic [7:0] byte_val;
  op_shape_t shape;

  qfd_nib_pack u_pack (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_en(sck_en), .io_in(io_in),
    .nib_stb(nib_stb), .byte_stb(byte_stb), .byte_val(byte_val)
  );

  qfd_shape_lut u_lut (.op(byte_val), .shape(shape));

  qfd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy),
    .nib_stb(nib_stb), .byte_stb(byte_stb), .byte_val(byte_val), .shape(shape),
    .rd_req(rd_req), .wr_valid(wr_valid), .wr_data(wr_data),
    .cmd_commit(cmd_commit), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_nbytes(cmd_nbytes)
  );
endmodule

// File: rtl/qfd_chk.sv
module qfd_chk
  import qfd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rd_req,
  input logic             wr_valid,
  input logic             cmd_commit,
  input logic [CNT_W-1:0] cmd_nbytes
);
  // R5
  wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(cs_n));
  // R6
  commit_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_commit |-> $past(cs_n));
  // R6
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_commit |=> !cmd_commit);
  // R4
  no_dir_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_valid));
  // R8
  nbytes_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_commit |-> (cmd_nbytes <= CNT_W'(PROG_MAX)));
endmodule

bind qfd_top qfd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_req(rd_req),
  .wr_valid(wr_valid), .cmd_commit(cmd_commit), .cmd_nbytes(cmd_nbytes)
);

// File: tb/tb_qfd_top.sv
module tb_qfd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck_en = 1'b0;
  logic [3:0]  io_in = '0;
  logic        busy = 1'b0;
  logic        rd_req, wr_valid, cmd_commit;
  logic [7:0]  wr_data, cmd_op;
  logic [23:0] cmd_addr;
  logic [8:0]  cmd_nbytes;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  qfd_top dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_en(sck_en), .io_in(io_in),
    .busy(busy), .rd_req(rd_req), .wr_valid(wr_valid), .wr_data(wr_data),
    .cmd_commit(cmd_commit), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_nbytes(cmd_nbytes)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural opcode knowledge: rdmax -1 = not a read, 0 = uncapped
  task automatic info(input logic [7:0] op, output bit kn, output int na,
                      output int dm, output int rdmax, output int wrmax,
                      output bit poll);
    kn = 1; na = 0; dm = 0; rdmax = -1; wrmax = 0; poll = 0;
    if (op inside {8'h0B, 8'h6B, 8'hEB, 8'h4B, 8'h02, 8'h32, 8'h12, 8'h42,
                   8'h20, 8'hD8, 8'hE8, 8'hE5}) na = 3;
    if (op inside {8'h0B, 8'h6B, 8'hEB, 8'h4B}) dm = 10;
    if (op inside {8'h0B, 8'h6B, 8'hEB, 8'h05, 8'hE8, 8'h70}) rdmax = 0;
    if (op == 8'hAF) rdmax = 3;
    if (op == 8'h4B) rdmax = 65;
    if (op == 8'hB5) rdmax = 2;
    if (op inside {8'h02, 8'h32, 8'h12}) wrmax = 256;
    if (op == 8'h42) wrmax = 65;
    if (op inside {8'h01, 8'hE5}) wrmax = 1;
    if (op inside {8'h05, 8'h70, 8'h75}) poll = 1;
    if (!(op inside {8'hAF, 8'h0B, 8'h6B, 8'hEB, 8'h4B, 8'h06, 8'h04, 8'h02,
                     8'h32, 8'h12, 8'h42, 8'h20, 8'hD8, 8'hC7, 8'h7A, 8'h75,
                     8'h05, 8'h01, 8'hE8, 8'hE5, 8'h70, 8'h50, 8'hB5})) kn = 0;
  endtask

  // reference model
  bit e_rd, e_wr, e_cm;
  logic [7:0] e_wd, m_op;
  logic [23:0] m_addr;
  int e_nb;
  int ph, half, abyt, dmc, cnt;
  logic [3:0] hi;
  bit m_csp;

  task automatic enter();
    bit kn, pl; int na, dm, rx, wx;
    info(m_op, kn, na, dm, rx, wx, pl);
    ph = 3;
    if (rx >= 0) begin e_rd = 1; cnt = 1; end else cnt = 0;
  endtask

  always @(posedge clk) begin
    bit kn, pl, got; int na, dm, rx, wx; logic [7:0] b;
    if (!rst_n) begin
      e_rd = 0; e_wr = 0; e_cm = 0; ph = 0; half = 0; abyt = 0; dmc = 0;
      cnt = 0; m_csp = 1; m_op = 0; m_addr = 0; e_nb = 0; e_wd = 0;
    end else begin
      e_rd = 0; e_wr = 0; e_cm = 0;
      info(m_op, kn, na, dm, rx, wx, pl);
      if (cs_n) begin
        if (!m_csp) begin
          e_cm = (ph == 3) && (wx == 0 || cnt > 0);
          e_nb = (wx != 0) ? cnt : 0;
        end
        ph = 0; half = 0; abyt = 0; dmc = 0; cnt = 0;
      end else if (sck_en) begin
        got = 0; b = 0;
        if (half != 0) begin b = {hi, io_in}; got = 1; end else hi = io_in;
        half = (half != 0) ? 0 : 1;
        case (ph)
          0: if (got) begin
            m_op = b; m_addr = 0;
            info(m_op, kn, na, dm, rx, wx, pl);
            if (!kn || (busy && !pl)) ph = 4;
            else if (na > 0) ph = 1;
            else enter();
          end
          1: if (got) begin
            m_addr = {m_addr[15:0], b}; abyt++;
            if (abyt == na) begin if (dm > 0) ph = 2; else enter(); end
          end
          2: begin dmc++; if (dmc == dm) enter(); end
          3: if (got) begin
            if (wx > 0 && cnt < wx) begin e_wr = 1; e_wd = b; cnt++; end
            if (rx >= 0 && (rx == 0 || cnt < rx)) begin
              e_rd = 1; if (rx > 0) cnt++;
            end
          end
          default: ;
        endcase
      end
      m_csp = cs_n;
    end
  end

  // per-cycle comparison and frame tallies
  int n_rd, n_wr, n_cm, last_nb;
  logic [7:0] last_op;
  logic [23:0] last_addr;
  always @(negedge clk) if (rst_n) begin
    check("R4 rd_req", int'(rd_req), int'(e_rd));
    check("R5 wr_valid", int'(wr_valid), int'(e_wr));
    if (e_wr) check("R5 wr_data", int'(wr_data), int'(e_wd));
    check("R6 commit", int'(cmd_commit), int'(e_cm));
    if (e_cm) begin
      check("R8 op", int'(cmd_op), int'(m_op));
      check("R2 addr", int'(cmd_addr), int'(m_addr));
      check("R8 nbytes", int'(cmd_nbytes), e_nb);
    end
    if (rd_req) n_rd++;
    if (wr_valid) n_wr++;
    if (cmd_commit) begin
      n_cm++; last_nb = int'(cmd_nbytes); last_op = cmd_op; last_addr = cmd_addr;
    end
  end

  task automatic frame(input logic [7:0] op, input bit has_a, input logic [23:0] a,
                       input int ndm, input int nd, input int cap);
    logic [3:0] q[$];
    n_rd = 0; n_wr = 0; n_cm = 0; last_nb = -1;
    q.push_back(op[7:4]); q.push_back(op[3:0]);
    if (has_a) for (int i = 2; i >= 0; i--) begin
      q.push_back(a[i*8+4 +: 4]); q.push_back(a[i*8 +: 4]);
    end
    for (int i = 0; i < ndm; i++) q.push_back(4'h0);
    for (int i = 0; i < nd; i++) begin
      logic [7:0] d; d = 8'((i * 7 + 3) & 255);
      q.push_back(d[7:4]); q.push_back(d[3:0]);
    end
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < q.size() && (cap < 0 || i < cap); i++) begin
      sck_en = 1'b1; io_in = q[i];
      @(negedge clk);
    end
    sck_en = 1'b0; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9
    check("R9 rd_req reset", int'(rd_req), 0);
    check("R9 wr_valid reset", int'(wr_valid), 0);
    check("R9 commit reset", int'(cmd_commit), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    frame(8'h06, 0, 0, 0, 2, -1);               // R10
    check("R10 commit", n_cm, 1); check("R10 wr", n_wr, 0); check("R10 rd", n_rd, 0);
    frame(8'hAF, 0, 0, 0, 5, -1);               // R4 cap 3
    check("R4 AF reqs", n_rd, 3); check("R1 op", int'(last_op), 8'hAF);
    frame(8'h0B, 1, 24'h123456, 10, 4, -1);     // R3 uncapped
    check("R3 0B reqs", n_rd, 5); check("R2 addr", int'(last_addr), 24'h123456);
    frame(8'hB5, 0, 0, 0, 4, -1);
    check("R4 B5 reqs", n_rd, 2);
    frame(8'h4B, 1, 24'h000100, 10, 70, -1);
    check("R4 4B reqs", n_rd, 65);
    frame(8'h02, 1, 24'hABCDEF, 0, 300, -1);
    check("R5 02 wr", n_wr, 256); check("R8 02 nbytes", last_nb, 256);
    check("R2 02 addr", int'(last_addr), 24'hABCDEF);
    frame(8'h42, 1, 24'h000010, 0, 70, -1);
    check("R5 42 wr", n_wr, 65);
    frame(8'h01, 0, 0, 0, 2, -1);
    check("R5 01 wr", n_wr, 1); check("R8 01 nbytes", last_nb, 1);
    frame(8'hE5, 1, 24'h00F000, 0, 2, -1);
    check("R5 E5 wr", n_wr, 1);
    frame(8'h02, 1, 24'h000001, 0, 0, -1);      // R6 no data
    check("R6 empty write", n_cm, 0);
    frame(8'hD8, 1, 24'h330000, 0, 0, 6);       // R6 truncated address
    check("R6 trunc addr", n_cm, 0);
    frame(8'hD8, 1, 24'h330000, 0, 0, -1);
    check("R6 full erase", n_cm, 1);
    frame(8'h9F, 0, 0, 0, 3, -1);               // R1 unknown
    check("R1 unk rd", n_rd, 0); check("R1 unk wr", n_wr, 0); check("R1 unk cm", n_cm, 0);
    frame(8'h0B, 1, 24'h000040, 8, 0, 16);      // R3 ends in dummies
    check("R3 short dummy rd", n_rd, 0); check("R3 short dummy cm", n_cm, 0);

    busy = 1'b1;                                // R7
    frame(8'h02, 1, 24'h000002, 0, 4, -1);
    check("R7 busy prog wr", n_wr, 0); check("R7 busy prog cm", n_cm, 0);
    frame(8'h0B, 1, 24'h000003, 10, 2, -1);
    check("R7 busy read", n_rd, 0);
    frame(8'h05, 0, 0, 0, 3, -1);
    check("R7 busy poll rd", n_rd, 4); check("R7 busy poll cm", n_cm, 1);
    frame(8'h75, 0, 0, 0, 0, -1);
    check("R7 busy suspend", n_cm, 1);
    busy = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule